// File: doc/BRIEF.md
# Root Port Error and PME Interrupt Controller

This block holds the 16-bit root-control register of a root port. It turns incoming error events and power-management event (PME) messages into a system-error pulse and a level PME interrupt. Software reaches the register through a configuration read/write port with byte enables. Only the low nibble is writable. Bit 3 enables the PME interrupt, and bits 2:0 enable system-error reporting per severity.

Error events arrive on two 3-bit strobe vectors: one for errors found by the port itself and one for errors reported from below it. In each vector, bit 0 is correctable, bit 1 is non-fatal uncorrectable and bit 2 is fatal. These strobes, the PME message strobe and the status-clear strobe are single-cycle event pins. They have no valid/ready handshake: the block has no back-pressure and takes every event in the cycle it arrives.

The PME status flag is set by any PME message. The interrupt is the status gated by the enable. Enabling while status is pending raises the interrupt, and disabling it drops the interrupt.

Top module: `rp_err_pme_ctl`

## Requirements
- R1: After reset, cfg_rdata is 0x0000 and pme_sts, pme_irq and serr_pulse are 0.
- R2: Bits 15:5 and bit 4 of cfg_rdata always read 0; writing ones to them has no effect on the read value.
- R3: A write takes effect on the clock edge at which cfg_wr is high. cfg_be[0] gates bits 7:0 and cfg_be[1] gates bits 15:8. A write with cfg_be[0]=0 leaves bits 3:0 unchanged.
- R4: A PME message (pme_msg high for a cycle) sets pme_sts at the next edge whatever bit 3 holds. pme_irq is raised only when bit 3 is 1.
- R5: When bit 3 goes from 0 to 1 while pme_sts is 1, pme_irq is high in the cycle after the write.
- R6: When bit 3 goes from 1 to 0, pme_irq is low in the cycle after the write and pme_sts keeps its value.
- R7: pme_sts_clr clears pme_sts and deasserts pme_irq at the next edge. If pme_msg arrives in the same cycle, the flag stays set.
- R8: An error strobe whose severity enable is 1 (bit 0 correctable, bit 1 non-fatal, bit 2 fatal) gives serr_pulse high for exactly the next cycle.
- R9: An error strobe whose severity enable is 0 gives no serr_pulse.
- R10: Enabled errors from the port itself (err_self) and from below it (err_below) raise serr_pulse alike.
- R11: The cmd_serr_en input has no effect on serr_pulse.
- R12: Any number of qualifying strobes in one cycle give a single one-cycle serr_pulse. With no qualifying strobe, serr_pulse is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current register value |
| pme_msg | input | 1 | PME message received strobe |
| pme_sts_clr | input | 1 | Write-1-to-clear strobe for PME status |
| err_self | input | 3 | Error strobes detected by the port, one per severity |
| err_below | input | 3 | Error strobes reported from downstream, one per severity |
| cmd_serr_en | input | 1 | General system-error enable from the command register (not used for gating) |
| pme_sts | output | 1 | PME status flag |
| pme_irq | output | 1 | Level PME interrupt |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
The hardest case to reach is the late-enable interrupt. A PME message must land while bit 3 is clear, so that status is set with no interrupt. A later configuration write must then set bit 3 alone. The bench does this with a message strobe, followed by a byte-lane-0 write of 0x0008, and checks that the interrupt rises in the cycle after that write.

It also covers the race where a clear strobe and a new message arrive in the same cycle. To do so it drives both pins together after status has been cleared once.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int RC_REG_W   = 16;
  localparam int RC_SEV_N   = 3;
  localparam int RC_PME_BIT = 3;
  localparam logic [RC_REG_W-1:0] RC_WR_MASK = 16'h000F;

  typedef struct packed {
    logic                pme_en;
    logic [RC_SEV_N-1:0] sev_en;
  } rc_ctl_t;
endpackage

// File: rtl/rp_ctl_reg.sv
module rp_ctl_reg
  import rp_pkg::*;
#(
  parameter int                REG_W   = RC_REG_W,
  parameter logic [REG_W-1:0]  WR_MASK = RC_WR_MASK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [REG_W/8-1:0]   be,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output rc_ctl_t              ctl
);
  localparam int LANES = REG_W / 8;

  logic [REG_W-1:0] reg_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [7:0] LMASK = WR_MASK[l*8 +: 8];
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (wr && be[l])
        lane_q <= wdata[l*8 +: 8] & LMASK;
    end
    assign reg_q[l*8 +: 8] = lane_q;
  end

  assign rdata      = reg_q;
  assign ctl.pme_en = reg_q[RC_PME_BIT];
  assign ctl.sev_en = reg_q[RC_SEV_N-1:0];

  // R3
  lane0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && be[0])) |=> $stable(ctl));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (rdata[REG_W-1:4] == '0));
endmodule

// File: rtl/rp_pme_unit.sv
module rp_pme_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic pme_en,
  input  logic msg,
  input  logic clr,
  output logic sts,
  output logic irq
);
  logic sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sts_q <= 1'b0;
    else if (msg)
      sts_q <= 1'b1;
    else if (clr)
      sts_q <= 1'b0;
  end

  assign sts = sts_q;
  assign irq = sts_q & pme_en;

  // R4
  msg_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg |=> sts);

  // R7
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !msg) |=> (!sts && !irq));

  // R6
  dis_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pme_en) |-> !irq);

  // R5
  late_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pme_en) && sts) |-> irq);
endmodule

// File: rtl/rp_serr_unit.sv
module rp_serr_unit
  import rp_pkg::*;
#(
  parameter int SEV_N = RC_SEV_N,
  parameter int SRC_N = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEV_N-1:0]       sev_en,
  input  logic [SRC_N*SEV_N-1:0] evt,
  input  logic                   cmd_en,
  output logic                   serr
);
  logic [SEV_N-1:0] merged [SRC_N+1];
  logic             serr_q;

  assign merged[0] = '0;
  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    assign merged[s+1] = merged[s] | evt[s*SEV_N +: SEV_N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      serr_q <= 1'b0;
    else
      serr_q <= |(merged[SRC_N] & sev_en);
  end

  assign serr = serr_q;

  // R9
  none_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sev_en == '0) |=> !serr);

  // R11
  cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_en && (|(evt[SEV_N-1:0] & sev_en))) |=> serr);

  // R12
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> !serr);
endmodule

// File: rtl/rp_err_pme_ctl.sv
module rp_err_pme_ctl
  import rp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_be,
  input  logic [15:0]         cfg_wdata,
  output logic [15:0]         cfg_rdata,
  input  logic                pme_msg,
  input  logic                pme_sts_clr,
  input  logic [2:0]          err_self,
  input  logic [2:0]          err_below,
  input  logic                cmd_serr_en,
  output logic                pme_sts,
  output logic                pme_irq,
  output logic                serr_pulse
);
  rc_ctl_t ctl;

  rp_ctl_reg #(.REG_W(RC_REG_W), .WR_MASK(RC_WR_MASK)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .ctl   (ctl)
  );

  rp_pme_unit u_pme (
    .clk    (clk),
    .rst_n  (rst_n),
    .pme_en (ctl.pme_en),
    .msg    (pme_msg),
    .clr    (pme_sts_clr),
    .sts    (pme_sts),
    .irq    (pme_irq)
  );

  rp_serr_unit #(.SEV_N(RC_SEV_N), .SRC_N(2)) u_serr (
    .clk    (clk),
    .rst_n  (rst_n),
    .sev_en (ctl.sev_en),
    .evt    ({err_below, err_self}),
    .cmd_en (cmd_serr_en),
    .serr   (serr_pulse)
  );

  // R8
  fatal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_self[2] || err_below[2]) && ctl.sev_en[2]) |=> serr_pulse);

  // R10
  below_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_below & ctl.sev_en)) |=> serr_pulse);
endmodule

// File: tb/sim_rp_err_pme_ctl.sv
module sim_rp_err_pme_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_be = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        pme_msg = 1'b0, pme_sts_clr = 1'b0;
  logic [2:0]  err_self = '0, err_below = '0;
  logic        cmd_serr_en = 1'b0;
  logic        pme_sts, pme_irq, serr_pulse;

  always #2.5 clk = ~clk;

  rp_err_pme_ctl u0 (.*);

  typedef struct {
    string       tag;
    logic [15:0] rd;
    logic        sts;
    logic        irq;
    logic        serr;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  logic [3:0] m_en  = '0;
  logic       m_sts = 1'b0;

  task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle and compares it
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "rdata", cfg_rdata, e.rd);
        cmp(e.tag, "pme_sts", {15'd0, pme_sts}, {15'd0, e.sts});
        cmp(e.tag, "pme_irq", {15'd0, pme_irq}, {15'd0, e.irq});
        cmp(e.tag, "serr", {15'd0, serr_pulse}, {15'd0, e.serr});
      end
    end
  end

  // driver: one cycle of stimulus, model computed from the requirements
  task automatic step(input logic wr, input logic [1:0] be, input logic [15:0] wd,
                      input logic msg, input logic clr, input logic [2:0] es,
                      input logic [2:0] eb, input logic cmd, input string tag);
    exp_t e;
    logic [3:0] n_en;
    logic       n_sts;
    @(negedge clk);
    cfg_wr = wr; cfg_be = be; cfg_wdata = wd;
    pme_msg = msg; pme_sts_clr = clr;
    err_self = es; err_below = eb; cmd_serr_en = cmd;
    n_en  = (wr && be[0]) ? wd[3:0] : m_en;
    n_sts = msg ? 1'b1 : (clr ? 1'b0 : m_sts);
    e.tag  = tag;
    e.rd   = {12'd0, n_en};
    e.sts  = n_sts;
    e.irq  = n_sts & n_en[3];
    e.serr = |((es | eb) & m_en[2:0]);
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    m_en = n_en;
    m_sts = n_sts;
  endtask

  task automatic idle(string tag);
    step(1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 3'b0, 3'b0, 1'b0, tag);
  endtask

  task automatic wreg(logic [1:0] be, logic [15:0] wd, string tag);
    step(1'b1, be, wd, 1'b0, 1'b0, 3'b0, 3'b0, 1'b0, tag);
  endtask

  initial begin
    int wd_cnt = 0;
    forever begin
      @(posedge clk);
      wd_cnt++;
      if (wd_cnt > 20000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    r.tag = "R1"; r.rd = '0; r.sts = 0; r.irq = 0; r.serr = 0;
    exp_q.push_back(r);
    @(posedge clk); #1;

    // R2 reserved and bit 4 read zero
    wreg(2'b11, 16'hFFFF, "R2");
    wreg(2'b11, 16'hFFF0, "R2_rsvd");
    // R3 byte enables
    wreg(2'b10, 16'h000F, "R3_be_hi");
    wreg(2'b01, 16'h0005, "R3_be_lo");
    wreg(2'b11, 16'h0000, "R3_clear");
    // R4 message with enable clear
    step(0, 2'b00, 16'h0, 1, 0, 3'b0, 3'b0, 0, "R4_noirq");
    idle("R4_hold");
    // R5 late enable
    wreg(2'b01, 16'h0008, "R5");
    // R6 disable drops interrupt
    wreg(2'b01, 16'h0000, "R6");
    wreg(2'b01, 16'h0008, "R5_again");
    // R7 clear and race
    step(0, 2'b00, 16'h0, 0, 1, 3'b0, 3'b0, 0, "R7_clr");
    step(0, 2'b00, 16'h0, 1, 1, 3'b0, 3'b0, 0, "R7_race");
    step(0, 2'b00, 16'h0, 0, 1, 3'b0, 3'b0, 0, "R7_clr2");
    // R4 message with enable set
    step(0, 2'b00, 16'h0, 1, 0, 3'b0, 3'b0, 0, "R4_irq");
    // R8 each severity enabled
    wreg(2'b01, 16'h000F, "R8_en");
    step(0, 2'b00, 16'h0, 0, 0, 3'b001, 3'b0, 1, "R8_corr");
    step(0, 2'b00, 16'h0, 0, 0, 3'b010, 3'b0, 1, "R8_nonfatal");
    step(0, 2'b00, 16'h0, 0, 0, 3'b100, 3'b0, 1, "R8_fatal");
    idle("R12_quiet");
    // R9 disabled severity
    wreg(2'b01, 16'h0005, "R9_en");
    step(0, 2'b00, 16'h0, 0, 0, 3'b010, 3'b0, 1, "R9_self");
    step(0, 2'b00, 16'h0, 0, 0, 3'b0, 3'b010, 1, "R9_below");
    // R10 downstream source
    step(0, 2'b00, 16'h0, 0, 0, 3'b0, 3'b100, 1, "R10_below");
    step(0, 2'b00, 16'h0, 0, 0, 3'b0, 3'b001, 1, "R10_below_corr");
    // R11 command enable low
    step(0, 2'b00, 16'h0, 0, 0, 3'b100, 3'b0, 0, "R11_cmd0");
    step(0, 2'b00, 16'h0, 0, 0, 3'b0, 3'b001, 0, "R11_cmd0_below");
    // R12 simultaneous events
    step(0, 2'b00, 16'h0, 0, 0, 3'b111, 3'b111, 1, "R12_multi");
    idle("R12_end");
    wreg(2'b01, 16'h0000, "R9_alloff");
    step(0, 2'b00, 16'h0, 0, 0, 3'b111, 3'b111, 1, "R9_none");
    idle("tail");
    idle("tail2");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule